// File: doc/BRIEF.md
# Static memory wait-state sequencer

This block times accesses to asynchronous static memories (SRAM, ROM, NOR flash) that sit behind a single-cycle internal request strobe. Up to four chip-select banks are served, one access at a time. Each bank has four 5-bit timing codes held in a small register file: the output-enable delay, the wait for a random (first) read, the wait for a sequential read inside an open page, and the write strobe length. All waits are counted in system clock cycles. The sequencer drives one active-low chip select per bank, a shared active-low output enable and write enable, the latched access address, and a one-cycle acknowledge at the end of every access.

A requester presents a request by raising `req_valid` for exactly one cycle, either while the sequencer is idle or in the cycle where `req_ack` is high. The second case chains accesses with no idle gap. A read chained onto a read to the same bank and the same page (all address bits above the low `PAGE_W` bits equal) takes the shorter page timing and keeps output enable asserted. Every other read uses the first-read timing. Timing codes are sampled when a request is taken, so register writes made during an access affect only later accesses.

The controller has four states. ST_IDLE goes to ST_READ or ST_WR_STROBE when a request is taken. ST_READ stays until its wait count expires. The expiry cycle is the acknowledge cycle, after which the state returns to ST_IDLE or, for a chained request, starts the next access. ST_WR_STROBE holds write enable until its count expires and then moves to ST_WR_HOLD. ST_WR_HOLD is a single cycle with write enable released and chip select still asserted; it acknowledges and leaves to ST_IDLE or to a chained access.

Top module: `smem_wait_seq`

## Requirements
- R1: After reset every `mem_cs_n` bit, `mem_oe_n` and `mem_we_n` are 1 and `req_ack` is 0. In every bank the output-enable delay code reads back 0 and the first-read, page and write codes read back 31.
- R2: Config address bits [6:5] select the bank and bits [3:2] select the code: 0 = output-enable delay, 1 = first read, 2 = page read, 3 = write. A write stores `cfg_wdata[4:0]`. Readback bits 31:5 are always 0. An address with bit 4 set stores nothing and reads 0.
- R3: A first read with read code r holds `mem_cs_n[bank]` low for r+1 cycles, starting in the cycle after the request is taken. `req_ack` is high only in the last of those cycles.
- R4: On a first read with output-enable delay code d, `mem_oe_n` is low in access cycle k (k = 0 for the first cycle) exactly when k >= d. It is never low if d > r.
- R5: A read taken in the acknowledge cycle of a read to the same bank and page lasts p+1 cycles, with p the page code, and holds `mem_oe_n` low in all of them.
- R6: A read uses first-read timing when the preceding access was to another bank, to another page, or a write, or when one or more idle cycles separate it from the preceding read.
- R7: A write with write code w holds chip select low for w+2 cycles. `mem_we_n` is low for the first w+1 cycles and high in the final acknowledge cycle, and `mem_oe_n` stays high.
- R8: A request taken in an acknowledge cycle starts at the next cycle with no cycle in which all chip selects are high.
- R9: A request raised during an access cycle that is not the acknowledge cycle is ignored: the access length is unchanged and the sequencer goes idle after the acknowledge.
- R10: A timing-code write made during an access leaves that access unchanged and applies from the next request.
- R11: At most one chip select is low at a time. `req_ack` occurs only while a chip select is low, and `mem_addr` holds the taken request address for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all waits counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 7 | Timing register address (bank in [6:5], code in [3:2]) |
| cfg_wdata | input | 32 | Timing register write data, bits 4:0 stored |
| cfg_rdata | output | 32 | Timing register read data for `cfg_addr` |
| req_valid | input | 1 | One-cycle access request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bank | input | 2 | Target chip-select bank |
| req_addr | input | 16 | Access address |
| req_ack | output | 1 | One-cycle pulse in the last cycle of an access |
| mem_addr | output | 16 | Latched address of the current access |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
The bench sweeps every first-read code against several output-enable delays, including delays equal to, one past and far past the read length. An off-by-one in the counter or a wrong comparison direction in the enable logic shows up as a wrong access length or a misplaced first enable cycle. It sweeps every page code and every write code through chained accesses. A sequencer that inserted an idle cycle between chained accesses, ended the write strobe late, or took the wrong code for sequential reads would drop a chip-select cycle or report the wrong length. It also tests the cases that must fall back to first-read timing (other page, other bank, after a write, after an idle cycle), stray requests in the middle of an access, and register writes during an access. A design that tracked pages too loosely, accepted requests early, or read timing live from the registers would fail these cases.

// File: rtl/smem_wait_pkg.sv
package smem_wait_pkg;

    localparam int WAIT_W = 5;

    typedef logic [WAIT_W-1:0] wait_code_t;

    localparam wait_code_t WAIT_CODE_MAX = '1;
    localparam wait_code_t OEN_CODE_RST  = '0;

    typedef struct packed {
        wait_code_t oen;
        wait_code_t rd;
        wait_code_t page;
        wait_code_t wr;
    } bank_timing_t;

    typedef enum logic [1:0] {
        SEL_OEN  = 2'd0,
        SEL_RD   = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_WR   = 2'd3
    } code_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ      = 2'd1,
        ST_WR_STROBE = 2'd2,
        ST_WR_HOLD   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/smem_wait_regs.sv
module smem_wait_regs
    import smem_wait_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int REG_W     = 32,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CFG_AW   = BANK_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [BANK_W-1:0] lookup_bank,
    output bank_timing_t      lookup_timing
);

    localparam logic [BANK_W:0] BANK_LIM = NUM_BANKS[BANK_W:0];

    bank_timing_t      tbl_q [NUM_BANKS];
    logic [BANK_W-1:0] cfg_bank;
    code_sel_e         cfg_sel;
    logic              cfg_hit;
    logic              lookup_ok;
    wait_code_t        wr_code;
    logic              unused_cfg_bits;

    assign cfg_bank  = cfg_addr[CFG_AW-1:5];
    assign cfg_sel   = code_sel_e'(cfg_addr[3:2]);
    assign cfg_hit   = !cfg_addr[4] && ({1'b0, cfg_bank} < BANK_LIM);
    assign wr_code   = cfg_wdata[WAIT_W-1:0];
    assign lookup_ok = ({1'b0, lookup_bank} < BANK_LIM);
    assign unused_cfg_bits = ^{cfg_addr[1:0], cfg_wdata[REG_W-1:WAIT_W]};

    // storage: one process for all banks, each bank written only on a hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                tbl_q[b].oen  <= OEN_CODE_RST;
                tbl_q[b].rd   <= WAIT_CODE_MAX;
                tbl_q[b].page <= WAIT_CODE_MAX;
                tbl_q[b].wr   <= WAIT_CODE_MAX;
            end
        end else if (cfg_we && cfg_hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cfg_bank == BANK_W'(b)) begin
                    unique case (cfg_sel)
                        SEL_OEN:  tbl_q[b].oen  <= wr_code;
                        SEL_RD:   tbl_q[b].rd   <= wr_code;
                        SEL_PAGE: tbl_q[b].page <= wr_code;
                        SEL_WR:   tbl_q[b].wr   <= wr_code;
                    endcase
                end
            end
        end
    end

    // readback: upper bits forced to zero, unmapped addresses read zero
    always_comb begin
        cfg_rdata = '0;
        if (cfg_hit) begin
            unique case (cfg_sel)
                SEL_OEN:  cfg_rdata[WAIT_W-1:0] = tbl_q[cfg_bank].oen;
                SEL_RD:   cfg_rdata[WAIT_W-1:0] = tbl_q[cfg_bank].rd;
                SEL_PAGE: cfg_rdata[WAIT_W-1:0] = tbl_q[cfg_bank].page;
                SEL_WR:   cfg_rdata[WAIT_W-1:0] = tbl_q[cfg_bank].wr;
            endcase
        end
    end

    always_comb begin
        lookup_timing = '0;
        if (lookup_ok) begin
            lookup_timing = tbl_q[lookup_bank];
        end
    end

endmodule

// File: rtl/smem_access_ctx.sv
module smem_access_ctx #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              read_done,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [BANK_W-1:0] cur_bank,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              seq_hit
);

    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic              same_bank;
    logic              same_page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            bank_q <= req_bank;
            addr_q <= req_addr;
        end
    end

    assign same_bank = (req_bank == bank_q);
    assign same_page = (req_addr[ADDR_W-1:PAGE_W] == addr_q[ADDR_W-1:PAGE_W]);

    // sequential only while a read is finishing in this very cycle
    assign seq_hit  = read_done && !req_write && same_bank && same_page;
    assign cur_bank = bank_q;
    assign cur_addr = addr_q;

endmodule

// File: rtl/smem_wait_fsm.sv
module smem_wait_fsm
    import smem_wait_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic         seq_hit,
    input  bank_timing_t timing,
    output logic         accept,
    output logic         ack,
    output logic         read_done,
    output logic         active,
    output logic         oe_n,
    output logic         we_n
);

    seq_state_e state_q, state_d;
    wait_code_t elapsed_q, elapsed_d;
    wait_code_t limit_q, limit_d;
    wait_code_t oen_q, oen_d;
    logic       burst_q, burst_d;
    logic       count_done;

    assign count_done = (elapsed_q == limit_q);

    // next-state and snapshot of timing at the moment a request is taken
    always_comb begin
        read_done = (state_q == ST_READ) && count_done;
        ack       = read_done || (state_q == ST_WR_HOLD);
        accept    = req_valid && ((state_q == ST_IDLE) || ack);

        state_d   = state_q;
        elapsed_d = elapsed_q;
        limit_d   = limit_q;
        oen_d     = oen_q;
        burst_d   = burst_q;

        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_IDLE;
            end
            ST_READ: begin
                if (count_done) begin
                    state_d = ST_IDLE;
                end else begin
                    elapsed_d = elapsed_q + 1'b1;
                end
            end
            ST_WR_STROBE: begin
                if (count_done) begin
                    state_d = ST_WR_HOLD;
                end else begin
                    elapsed_d = elapsed_q + 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
        endcase

        if (accept) begin
            elapsed_d = '0;
            oen_d     = timing.oen;
            if (req_write) begin
                state_d = ST_WR_STROBE;
                limit_d = timing.wr;
                burst_d = 1'b0;
            end else begin
                state_d = ST_READ;
                limit_d = seq_hit ? timing.page : timing.rd;
                burst_d = seq_hit;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            elapsed_q <= '0;
            limit_q   <= '0;
            oen_q     <= '0;
            burst_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            elapsed_q <= elapsed_d;
            limit_q   <= limit_d;
            oen_q     <= oen_d;
            burst_q   <= burst_d;
        end
    end

    // strobe outputs
    always_comb begin
        active = (state_q != ST_IDLE);
        oe_n   = 1'b1;
        we_n   = 1'b1;
        unique case (state_q)
            ST_IDLE:      ;
            ST_READ:      oe_n = !(burst_q || (elapsed_q >= oen_q));
            ST_WR_STROBE: we_n = 1'b0;
            ST_WR_HOLD:   ;
        endcase
    end

endmodule

// File: rtl/smem_wait_seq.sv
module smem_wait_seq
    import smem_wait_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 2,
    parameter int REG_W     = 32,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CFG_AW   = BANK_W + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ack,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n
);

    bank_timing_t      req_timing;
    logic              accept;
    logic              ack;
    logic              read_done;
    logic              active;
    logic              seq_hit;
    logic [BANK_W-1:0] cur_bank;

    smem_wait_regs #(
        .NUM_BANKS (NUM_BANKS),
        .REG_W     (REG_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .lookup_bank   (req_bank),
        .lookup_timing (req_timing)
    );

    smem_access_ctx #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .read_done (read_done),
        .req_write (req_write),
        .req_bank  (req_bank),
        .req_addr  (req_addr),
        .cur_bank  (cur_bank),
        .cur_addr  (mem_addr),
        .seq_hit   (seq_hit)
    );

    smem_wait_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .seq_hit   (seq_hit),
        .timing    (req_timing),
        .accept    (accept),
        .ack       (ack),
        .read_done (read_done),
        .active    (active),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n)
    );

    assign req_ack = ack;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
        localparam logic [BANK_W-1:0] IDX = BANK_W'(g);
        assign mem_cs_n[g] = !(active && (cur_bank == IDX));
    end

endmodule

// File: rtl/smem_wait_chk.sv
module smem_wait_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ack,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [NUM_BANKS-1:0] mem_cs_n,
    input logic                 mem_oe_n,
    input logic                 mem_we_n
);

    logic any_cs;
    assign any_cs = !(&mem_cs_n);

    a_r11_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    a_r11_ack_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> any_cs);

    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cs && !req_ack) |=> $stable(mem_addr));

    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && !req_valid) |=> !req_ack);

    a_r4_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (any_cs && mem_we_n));

    a_r7_we_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (any_cs && !req_ack));

    a_r7_we_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && any_cs) |-> req_ack);

endmodule

bind smem_wait_seq smem_wait_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/smem_wait_seq_tb_top.sv
module smem_wait_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic        req_ack;
    logic [15:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int sh [4][4];
    int o_len, o_oe, o_oe_first, o_we, o_we_last, o_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    smem_wait_seq dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .req_valid (req_valid), .req_write (req_write), .req_bank (req_bank), .req_addr (req_addr),
        .req_ack (req_ack), .mem_addr (mem_addr), .mem_cs_n (mem_cs_n),
        .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [6:0] reg_addr(int b, int i);
        return {2'(b), 1'b0, 2'(i), 2'b00};
    endfunction

    task automatic cfg_write(int b, int i, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = reg_addr(b, i); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        sh[b][i] = int'(d[4:0]);
    endtask

    task automatic cfg_read(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic drive_req(bit w, int b, logic [15:0] a);
        req_valid = 1'b1; req_write = w; req_bank = 2'(b); req_addr = a;
    endtask

    task automatic issue(bit w, int b, logic [15:0] a);
        @(negedge clk);
        drive_req(w, b, a);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // called at the sample point of access cycle 0
    task automatic observe(int b, logic [15:0] a, bit chain, bit nw, int nb,
                           logic [15:0] na, int poke_k, int cfg_k);
        int k;
        logic [3:0] exp_cs;
        k = 0;
        o_len = 0; o_oe = 0; o_oe_first = -1; o_we = 0; o_we_last = -1; o_bad = 0;
        exp_cs = ~(4'b0001 << b);
        forever begin
            req_valid = 1'b0;
            cfg_we = 1'b0;
            if (mem_cs_n !== exp_cs || mem_addr !== a) o_bad++;
            if (!mem_oe_n) begin
                o_oe++;
                if (o_oe_first < 0) o_oe_first = k;
            end
            if (!mem_we_n) begin
                o_we++;
                o_we_last = k;
            end
            if (req_ack === 1'b1) begin
                o_len = k + 1;
                if (chain) drive_req(nw, nb, na);
                break;
            end
            if (k == poke_k) drive_req(1'b0, (b + 1) % 4, 16'h0000);
            if (k == cfg_k) begin
                cfg_we = 1'b1; cfg_addr = reg_addr(b, 1); cfg_wdata = 32'h0;
            end
            k++;
            if (k > 200) begin
                o_len = -1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic exp_first_read(string tag, int b);
        int r, d;
        r = sh[b][1]; d = sh[b][0];
        check(o_len == r + 1, tag, "first read length", o_len, r + 1);
        check(o_oe == ((d <= r) ? r + 1 - d : 0), tag, "oe cycles", o_oe, (d <= r) ? r + 1 - d : 0);
        check(o_oe_first == ((d <= r) ? d : -1), tag, "first oe cycle", o_oe_first, (d <= r) ? d : -1);
        check(o_bad == 0, "R11", "cs/addr mismatches", o_bad, 0);
    endtask

    task automatic exp_seq_read(string tag, int b);
        int p;
        p = sh[b][2];
        check(o_len == p + 1, tag, "page read length", o_len, p + 1);
        check(o_oe == p + 1, tag, "page oe cycles", o_oe, p + 1);
        check(o_bad == 0, "R8", "cs/addr mismatches in chained access", o_bad, 0);
    endtask

    task automatic exp_write(string tag, int b);
        int w;
        w = sh[b][3];
        check(o_len == w + 2, tag, "write length", o_len, w + 2);
        check(o_we == w + 1, tag, "we cycles", o_we, w + 1);
        check(o_we_last == w, tag, "last we cycle", o_we_last, w);
        check(o_oe == 0, tag, "oe during write", o_oe, 0);
        check(o_bad == 0, "R11", "cs/addr mismatches", o_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        for (int b = 0; b < 4; b++) begin
            sh[b][0] = 0; sh[b][1] = 31; sh[b][2] = 31; sh[b][3] = 31;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(mem_cs_n == 4'hF, "R1", "cs after reset", int'(mem_cs_n), 15);
        check(mem_oe_n && mem_we_n, "R1", "oe/we after reset", int'({mem_oe_n, mem_we_n}), 3);
        check(req_ack == 1'b0, "R1", "ack after reset", int'(req_ack), 0);
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 4; i++) begin
                cfg_read(reg_addr(b, i), rd);
                check(rd == ((i == 0) ? 0 : 31), "R1", "reset code", int'(rd), (i == 0) ? 0 : 31);
            end
        end

        // R2: storage, readback masking, unmapped hole
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 4; i++) begin
                cfg_write(b, i, 32'hA5A5_A5E0 | 32'((b * 4 + i + 3) % 32));
            end
        end
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 4; i++) begin
                cfg_read(reg_addr(b, i), rd);
                check(rd == 32'((b * 4 + i + 3) % 32), "R2", "readback", int'(rd), (b * 4 + i + 3) % 32);
            end
        end
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'h10; cfg_wdata = 32'h7;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_read(7'h10, rd);
        check(rd == 0, "R2", "hole reads zero", int'(rd), 0);
        for (int i = 0; i < 4; i++) begin
            cfg_read(reg_addr(0, i), rd);
            check(rd == 32'(sh[0][i]), "R2", "hole write ignored", int'(rd), sh[0][i]);
        end

        // R3, R4: first-read sweep over every read code with several enable delays
        for (int r = 0; r < 32; r++) begin
            cfg_write(1, 1, 32'(r));
            for (int v = 0; v < 4; v++) begin
                int d;
                d = (v == 0) ? 0 : (v == 1) ? r / 2 : (v == 2) ? ((r < 31) ? r + 1 : r) : 31;
                cfg_write(1, 0, 32'(d));
                issue(1'b0, 1, 16'h0040 + 16'(r));
                observe(1, 16'h0040 + 16'(r), 1'b0, 1'b0, 0, 16'h0, -1, -1);
                exp_first_read("R3_R4", 1);
            end
        end

        // R7: write sweep
        for (int w = 0; w < 32; w++) begin
            cfg_write(2, 3, 32'(w));
            issue(1'b1, 2, 16'h0200 + 16'(w));
            observe(2, 16'h0200 + 16'(w), 1'b0, 1'b0, 0, 16'h0, -1, -1);
            exp_write("R7", 2);
        end

        // R5, R8: page code sweep through chained sequential reads
        cfg_write(3, 1, 32'd4);
        cfg_write(3, 0, 32'd2);
        for (int p = 0; p < 32; p++) begin
            cfg_write(3, 2, 32'(p));
            issue(1'b0, 3, 16'h0104);
            observe(3, 16'h0104, 1'b1, 1'b0, 3, 16'h0105, -1, -1);
            exp_first_read("R5", 3);
            @(negedge clk); req_valid = 1'b0;
            observe(3, 16'h0105, 1'b1, 1'b0, 3, 16'h0107, -1, -1);
            exp_seq_read("R5", 3);
            @(negedge clk); req_valid = 1'b0;
            observe(3, 16'h0107, 1'b0, 1'b0, 0, 16'h0, -1, -1);
            exp_seq_read("R8", 3);
        end

        // R6: cases that must fall back to first-read timing
        cfg_write(3, 2, 32'd1);
        cfg_write(3, 1, 32'd6);
        cfg_write(3, 0, 32'd0);
        cfg_write(0, 1, 32'd3);
        cfg_write(0, 0, 32'd1);
        cfg_write(3, 3, 32'd2);
        issue(1'b0, 3, 16'h0300);
        observe(3, 16'h0300, 1'b1, 1'b0, 3, 16'h0304, -1, -1);
        @(negedge clk); req_valid = 1'b0;
        observe(3, 16'h0304, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        exp_first_read("R6", 3);
        issue(1'b0, 3, 16'h0300);
        observe(3, 16'h0300, 1'b1, 1'b0, 0, 16'h0301, -1, -1);
        @(negedge clk); req_valid = 1'b0;
        observe(0, 16'h0301, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        exp_first_read("R6", 0);
        issue(1'b1, 3, 16'h0300);
        observe(3, 16'h0300, 1'b1, 1'b0, 3, 16'h0301, -1, -1);
        exp_write("R6", 3);
        @(negedge clk); req_valid = 1'b0;
        observe(3, 16'h0301, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        exp_first_read("R6", 3);
        issue(1'b0, 3, 16'h0300);
        observe(3, 16'h0300, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        issue(1'b0, 3, 16'h0301);
        observe(3, 16'h0301, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        exp_first_read("R6", 3);
        issue(1'b0, 3, 16'h0300);
        observe(3, 16'h0300, 1'b1, 1'b0, 3, 16'h0301, -1, -1);
        @(negedge clk); req_valid = 1'b0;
        observe(3, 16'h0301, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        exp_seq_read("R6", 3);

        // R8: chained writes
        cfg_write(2, 3, 32'd3);
        issue(1'b1, 2, 16'h0500);
        observe(2, 16'h0500, 1'b1, 1'b1, 2, 16'h0501, -1, -1);
        @(negedge clk); req_valid = 1'b0;
        observe(2, 16'h0501, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        exp_write("R8", 2);

        // R9: stray request mid-access
        cfg_write(1, 1, 32'd20);
        cfg_write(1, 0, 32'd0);
        issue(1'b0, 1, 16'h0700);
        observe(1, 16'h0700, 1'b0, 1'b0, 0, 16'h0, 5, -1);
        check(o_len == 21, "R9", "length with stray request", o_len, 21);
        @(negedge clk);
        check(mem_cs_n == 4'hF, "R9", "idle after ack", int'(mem_cs_n), 15);
        check(req_ack == 1'b0, "R9", "no ack after ack", int'(req_ack), 0);

        // R10: timing write during an access
        cfg_write(1, 1, 32'd15);
        issue(1'b0, 1, 16'h0800);
        observe(1, 16'h0800, 1'b0, 1'b0, 0, 16'h0, -1, 3);
        check(o_len == 16, "R10", "old timing kept", o_len, 16);
        sh[1][1] = 0;
        cfg_read(reg_addr(1, 1), rd);
        check(rd == 0, "R10", "new code stored", int'(rd), 0);
        issue(1'b0, 1, 16'h0900);
        observe(1, 16'h0900, 1'b0, 1'b0, 0, 16'h0, -1, -1);
        check(o_len == 1, "R10", "new timing applied", o_len, 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule